// File: doc/BRIEF.md
# Self-Timed SRAM Access Sequencer

This block steps a 64-word by 16-bit array of six-transistor cells through its read and write phases. No delay line and no cycle count sets how long a phase lasts. Each phase ends only when the array reports, on its complementary bitline pairs, that the phase has finished. So the access length follows the real speed of the array when the supply voltage drifts or the process corner shifts.

A requester uses a four-phase handshake. It raises `req_i` with the address, the write flag and the write data held stable. The sequencer raises `ack_o` once the access is complete, and keeps read data valid while `ack_o` is high. The requester then drops `req_i`. `ack_o` falls only after every bitline is high again.

On the array side the sequencer drives precharge, the word-line enable with its row address, and the write-driver enable with the data to drive. It reads back the true and complement bitline of every column, plus a per-column flag that says the selected cell now holds the driven value. If both lines of any column are ever seen low, the sequencer stops and raises an error flag that stays set until reset.

Top module: `stsq_sequencer`

## Requirements
- R1: While reset is held and after it is released, `pchg_o`=1, `wl_o`=0, `wdrv_o`=0, `ack_o`=0 and `err_o`=0.
- R2: `wl_o` never rises unless `pchg_o` was already 0 in the cycle before, and `pchg_o` and `wl_o` are never both 1.
- R3: A read opens the word line only after all 16 column pairs were seen fully precharged (both lines high). It keeps the word line open until every column shows exactly one line low.
- R4: A write turns on the drivers first. It opens the word line only once every column's true line equals the data bit and its complement line equals the inverted bit (a 1 discharges the complement line).
- R5: During a write the word line and the drivers stay on until every column's write-confirm input `wcnf_i` is 1.
- R6: `ack_o` rises only with the word line and drivers off. While `ack_o` stays high, `rdata_o` does not change.
- R7: `ack_o` stays high while `req_i` is high. It falls only after `req_i` is low and all bitlines were sensed high again.
- R8: If any column shows both bitlines low, `err_o` rises within one cycle and stays 1 until reset, with `pchg_o`, `wl_o` and `wdrv_o` at 0 and no further `ack_o`.
- R9: A read returns the true-line values sensed at completion, which equal the last value written at that address (true line high = stored 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock sampling completion conditions |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Handshake request from the requester |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Word address |
| wdata_i | input | 16 | Data to write |
| ack_o | output | 1 | Handshake acknowledge |
| rdata_o | output | 16 | Latched read data |
| err_o | output | 1 | Sticky error: a column had both lines low |
| pchg_o | output | 1 | Bitline precharge enable |
| wl_o | output | 1 | Word-line enable |
| wl_addr_o | output | 6 | Row selected by the word line |
| wdrv_o | output | 1 | Write-driver enable |
| wdrv_data_o | output | 16 | Data presented to the write drivers |
| bl_t_i | input | 16 | Sensed true bitline of each column |
| bl_f_i | input | 16 | Sensed complement bitline of each column |
| wcnf_i | input | 16 | Per-column confirm that the cell holds the driven bit |

## Verification
The array model settles each column at a random time in every phase. That exposes a sequencer that closes the word line once a single column resolves: it would latch stale or mixed read words. It also exposes one that opens the word line before precharge is seen complete or before the drivers have settled, since the cell would then be read or written through half-driven lines. The bench sweeps every address with arithmetic patterns and their complements, overwrites the first and last rows, and holds the request high for varying lengths. An acknowledge that drops early, or read data that moves while acknowledged, shows up at the ports. A shorted column is injected while idle: a design without a sticky halt would go on answering requests.

// File: rtl/stsq_pkg.sv
package stsq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_ISO    = 3'd1,
      ST_RD_WL  = 3'd2,
      ST_WR_DRV = 3'd3,
      ST_WR_WL  = 3'd4,
      ST_DONE   = 3'd5,
      ST_RECOV  = 3'd6,
      ST_HALT   = 3'd7
   } stsq_state_t;
endpackage

// File: rtl/stsq_col_sense.sv
module stsq_col_sense #(
   parameter int W = 16
) (
   input  logic [W-1:0] bl_t_i,
   input  logic [W-1:0] bl_f_i,
   input  logic [W-1:0] drv_data_i,
   input  logic [W-1:0] wcnf_i,
   output logic         pre_ok_o,
   output logic         rd_ok_o,
   output logic         wr_match_o,
   output logic         wr_cnf_o,
   output logic         short_o
);
   logic [W-1:0] col_high, col_one, col_match, col_short;

   for (genvar c = 0; c < W; c++) begin : g_col
      assign col_high[c]  = bl_t_i[c] & bl_f_i[c];
      assign col_one[c]   = bl_t_i[c] ^ bl_f_i[c];
      assign col_match[c] = (bl_t_i[c] == drv_data_i[c]) & (bl_f_i[c] == ~drv_data_i[c]);
      assign col_short[c] = ~(bl_t_i[c] | bl_f_i[c]);
   end

   assign pre_ok_o   = &col_high;
   assign rd_ok_o    = &col_one;
   assign wr_match_o = &col_match;
   assign wr_cnf_o   = &wcnf_i;
   assign short_o    = |col_short;
endmodule

// File: rtl/stsq_rdata_latch.sv
module stsq_rdata_latch #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cap_i,
   input  logic [W-1:0] bl_t_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= '0;
      else if (cap_i) q_o <= bl_t_i;
   end
endmodule

// File: rtl/stsq_fsm.sv
module stsq_fsm
   import stsq_pkg::*;
#(
   parameter int W  = 16,
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_i,
   input  logic          we_i,
   input  logic [AW-1:0] addr_i,
   input  logic [W-1:0]  wdata_i,
   input  logic          pre_ok_i,
   input  logic          rd_ok_i,
   input  logic          wr_match_i,
   input  logic          wr_cnf_i,
   input  logic          short_i,
   output logic          pchg_o,
   output logic          wl_o,
   output logic          wdrv_o,
   output logic          ack_o,
   output logic          err_o,
   output logic          cap_o,
   output logic [AW-1:0] addr_o,
   output logic [W-1:0]  wdata_o
);
   stsq_state_t state_q, state_d;
   logic        we_q;

   always_comb begin
      state_d = state_q;
      if (short_i) begin
         state_d = ST_HALT;
      end else begin
         unique case (state_q)
            ST_IDLE:   if (req_i && pre_ok_i) state_d = ST_ISO;
            ST_ISO:    state_d = we_q ? ST_WR_DRV : ST_RD_WL;
            ST_RD_WL:  if (rd_ok_i)    state_d = ST_DONE;
            ST_WR_DRV: if (wr_match_i) state_d = ST_WR_WL;
            ST_WR_WL:  if (wr_cnf_i)   state_d = ST_DONE;
            ST_DONE:   if (!req_i)     state_d = ST_RECOV;
            ST_RECOV:  if (pre_ok_i)   state_d = ST_IDLE;
            ST_HALT:   state_d = ST_HALT;
            default:   state_d = ST_HALT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         we_q    <= 1'b0;
         addr_o  <= '0;
         wdata_o <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && state_d == ST_ISO) begin
            we_q    <= we_i;
            addr_o  <= addr_i;
            wdata_o <= wdata_i;
         end
      end
   end

   always_comb begin
      pchg_o = (state_q == ST_IDLE) || (state_q == ST_RECOV);
      wl_o   = (state_q == ST_RD_WL) || (state_q == ST_WR_WL);
      wdrv_o = (state_q == ST_WR_DRV) || (state_q == ST_WR_WL);
      ack_o  = (state_q == ST_DONE) || (state_q == ST_RECOV);
      err_o  = (state_q == ST_HALT);
   end

   assign cap_o = (state_q == ST_RD_WL) && rd_ok_i && !short_i;

   assert_wl_after_pchg_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wl_o) |-> !$past(pchg_o) && !pchg_o);
   assert_rd_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wl_o) && !$past(wdrv_o) |-> $past(rd_ok_i));
   assert_wr_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wl_o) && wdrv_o |-> $past(wdrv_o) && $past(wr_match_i));
   assert_wr_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wl_o) && $past(wdrv_o) |-> $past(wr_cnf_i));
   assert_ack_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_o) |-> !wl_o && !wdrv_o);
   assert_ack_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack_o) |-> $past(pre_ok_i) && !$past(req_i, 2));
   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o && !wl_o && !wdrv_o && !pchg_o && !ack_o);
endmodule

// File: rtl/stsq_sequencer.sv
module stsq_sequencer #(
   parameter  int W     = 16,
   parameter  int DEPTH = 64,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_i,
   input  logic          we_i,
   input  logic [AW-1:0] addr_i,
   input  logic [W-1:0]  wdata_i,
   output logic          ack_o,
   output logic [W-1:0]  rdata_o,
   output logic          err_o,
   output logic          pchg_o,
   output logic          wl_o,
   output logic [AW-1:0] wl_addr_o,
   output logic          wdrv_o,
   output logic [W-1:0]  wdrv_data_o,
   input  logic [W-1:0]  bl_t_i,
   input  logic [W-1:0]  bl_f_i,
   input  logic [W-1:0]  wcnf_i
);
   if (W < 1 || DEPTH < 2 || DEPTH > (1 << AW)) begin : g_bad_cfg
      $error("stsq_sequencer: W must be >= 1 and DEPTH >= 2");
   end

   logic pre_ok, rd_ok, wr_match, wr_cnf, short_det, cap;

   stsq_col_sense #(.W(W)) u_sense (
      .bl_t_i     (bl_t_i),
      .bl_f_i     (bl_f_i),
      .drv_data_i (wdrv_data_o),
      .wcnf_i     (wcnf_i),
      .pre_ok_o   (pre_ok),
      .rd_ok_o    (rd_ok),
      .wr_match_o (wr_match),
      .wr_cnf_o   (wr_cnf),
      .short_o    (short_det)
   );

   stsq_fsm #(.W(W), .AW(AW)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req_i),
      .we_i       (we_i),
      .addr_i     (addr_i),
      .wdata_i    (wdata_i),
      .pre_ok_i   (pre_ok),
      .rd_ok_i    (rd_ok),
      .wr_match_i (wr_match),
      .wr_cnf_i   (wr_cnf),
      .short_i    (short_det),
      .pchg_o     (pchg_o),
      .wl_o       (wl_o),
      .wdrv_o     (wdrv_o),
      .ack_o      (ack_o),
      .err_o      (err_o),
      .cap_o      (cap),
      .addr_o     (wl_addr_o),
      .wdata_o    (wdrv_data_o)
   );

   stsq_rdata_latch #(.W(W)) u_rdata (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_i  (cap),
      .bl_t_i (bl_t_i),
      .q_o    (rdata_o)
   );

   assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o && $past(ack_o) |-> $stable(rdata_o));
   assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(pchg_o && wl_o));
   assert_short_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
      short_det |=> err_o);
endmodule

// File: tb/stsq_array_model.sv
module stsq_array_model #(
   parameter int W     = 16,
   parameter int DEPTH = 64,
   parameter int AW    = 6
) (
   input  logic          clk,
   input  logic          pchg,
   input  logic          wl,
   input  logic [AW-1:0] wl_addr,
   input  logic          wdrv,
   input  logic [W-1:0]  wdrv_data,
   input  logic          short_i,
   output logic [W-1:0]  bl_t,
   output logic [W-1:0]  bl_f,
   output logic [W-1:0]  wcnf
);
   logic [W-1:0] mem [DEPTH];
   logic [W-1:0] t_q, f_q, tgt_t, tgt_f, m, mw;

   initial begin
      for (int i = 0; i < DEPTH; i++) mem[i] = '0;
      t_q = '1;
      f_q = '1;
   end

   always_comb begin
      if (pchg) begin
         tgt_t = '1; tgt_f = '1;
      end else if (wdrv) begin
         tgt_t = wdrv_data; tgt_f = ~wdrv_data;
      end else if (wl) begin
         tgt_t = mem[wl_addr]; tgt_f = ~mem[wl_addr];
      end else begin
         tgt_t = t_q; tgt_f = f_q;
      end
   end

   always @(posedge clk) begin
      m  = W'($urandom) & W'($urandom);
      mw = W'($urandom) & W'($urandom);
      if ($urandom % 4 == 0) m = '0;
      t_q <= (t_q & ~m) | (tgt_t & m);
      f_q <= (f_q & ~m) | (tgt_f & m);
      if (wl && wdrv) mem[wl_addr] <= (mem[wl_addr] & ~mw) | (wdrv_data & mw);
   end

   assign bl_t = short_i ? (t_q & ~W'(1)) : t_q;
   assign bl_f = short_i ? (f_q & ~W'(1)) : f_q;
   assign wcnf = (wl && wdrv) ? ~(mem[wl_addr] ^ wdrv_data) : '0;
endmodule

// File: tb/stsq_sequencer_tb.sv
`timescale 1ns/1ps
module stsq_sequencer_tb;
   localparam int W = 16;
   localparam int DEPTH = 64;
   localparam int AW = 6;

   logic clk = 0, rst_n = 0;
   logic req = 0, we = 0;
   logic [AW-1:0] addr = '0;
   logic [W-1:0] wdata = '0;
   logic ack, err, pchg, wl, wdrv, short_en = 0;
   logic [W-1:0] rdata, wdrv_data, bl_t, bl_f, wcnf;
   logic [AW-1:0] wl_addr;

   int n_chk = 0, n_fail = 0, cyc = 0;
   logic [W-1:0] shadow [DEPTH];

   always #10 clk = ~clk;

   stsq_sequencer #(.W(W), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
      .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata), .err_o(err),
      .pchg_o(pchg), .wl_o(wl), .wl_addr_o(wl_addr), .wdrv_o(wdrv),
      .wdrv_data_o(wdrv_data), .bl_t_i(bl_t), .bl_f_i(bl_f), .wcnf_i(wcnf)
   );

   stsq_array_model #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_arr (
      .clk(clk), .pchg(pchg), .wl(wl), .wl_addr(wl_addr), .wdrv(wdrv),
      .wdrv_data(wdrv_data), .short_i(short_en), .bl_t(bl_t), .bl_f(bl_f),
      .wcnf(wcnf)
   );

   task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h (t=%0t)", rq, act, exp, $time);
      end
   endtask

   // ordering monitor, sampled away from the active edge
   logic p_wl = 0, p_pchg = 1, p_ack = 0, p_wdrv = 0;
   logic [W-1:0] p_t = '1, p_f = '1, p_cnf = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         chk(!(pchg && wl), "R2 overlap", {pchg, wl}, 2'b00);
         if (wl && !p_wl) begin
            chk(!p_pchg, "R2 precharge off before word line", p_pchg, 0);
            if (!wdrv) chk((p_t & p_f) == '1, "R3 precharged before read", p_t & p_f, 16'hffff);
            else begin
               chk(p_wdrv, "R4 drivers before word line", p_wdrv, 1);
               chk(p_t == wdrv_data && p_f == ~wdrv_data, "R4 bitlines match data",
                   {p_t, p_f}, {wdrv_data, ~wdrv_data});
            end
         end
         if (!wl && p_wl) begin
            if (!p_wdrv) chk((p_t ^ p_f) == '1, "R3 all columns resolved", p_t ^ p_f, 16'hffff);
            else chk(p_cnf == '1, "R5 all columns confirmed", p_cnf, 16'hffff);
         end
         if (ack && !p_ack) chk(!wl && !wdrv, "R6 ack with array quiet", {wl, wdrv}, 0);
         if (!ack && p_ack) chk((p_t & p_f) == '1, "R7 recovered before ack falls", p_t & p_f, 16'hffff);
      end
      p_wl = wl; p_pchg = pchg; p_ack = ack; p_wdrv = wdrv;
      p_t = bl_t; p_f = bl_f; p_cnf = wcnf;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected<150000", cyc);
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   task automatic access(input bit w, input logic [AW-1:0] a, input logic [W-1:0] d,
                         output logic [W-1:0] q);
      int n;
      logic [W-1:0] held;
      @(negedge clk);
      req = 1; we = w; addr = a; wdata = d;
      n = 0;
      while (!ack && n < 300) begin @(negedge clk); n++; end
      chk(ack, "R7 ack arrives", ack, 1);
      q = rdata; held = rdata;
      for (int k = 0; k < int'($urandom % 4); k++) begin
         @(negedge clk);
         chk(ack, "R7 ack held while req high", ack, 1);
         chk(rdata == held, "R6 rdata stable", rdata, held);
      end
      req = 0;
      n = 0;
      while (ack && n < 300) begin @(negedge clk); n++; end
      chk(!ack, "R7 ack released", ack, 0);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
      logic [W-1:0] q;
      access(1'b1, a, d, q);
      shadow[a] = d;
   endtask

   task automatic rd_chk(input logic [AW-1:0] a);
      logic [W-1:0] q;
      access(1'b0, a, '0, q);
      chk(q == shadow[a], "R9 read returns last write", q, shadow[a]);
   endtask

   task automatic chk_reset_state(input string tag);
      chk(pchg && !wl && !wdrv && !ack && !err, tag, {pchg, wl, wdrv, ack, err}, 5'b10000);
   endtask

   initial begin
      logic [W-1:0] q;
      for (int i = 0; i < DEPTH; i++) shadow[i] = '0;
      repeat (3) @(negedge clk);
      chk_reset_state("R1 during reset");
      rst_n = 1;
      repeat (2) @(negedge clk);
      chk_reset_state("R1 after reset");

      for (int a = 0; a < DEPTH; a++) wr(AW'(a), W'(a * 16'h0b05) ^ 16'h5a3c);
      for (int a = 0; a < DEPTH; a++) rd_chk(AW'(a));
      for (int a = DEPTH - 1; a >= 0; a--) wr(AW'(a), ~(W'(a * 16'h0b05) ^ 16'h5a3c));
      for (int a = 0; a < DEPTH; a++) rd_chk(AW'((a * 37) % DEPTH));

      wr('0, 16'h0000); wr('0, 16'hffff); rd_chk('0); rd_chk('0);
      wr(AW'(DEPTH - 1), 16'hffff); wr(AW'(DEPTH - 1), 16'h0000); rd_chk(AW'(DEPTH - 1));
      wr(AW'(21), 16'haaaa); wr(AW'(22), 16'h5555); rd_chk(AW'(21)); rd_chk(AW'(22));

      // shorted column while idle
      @(negedge clk); short_en = 1;
      @(negedge clk); @(negedge clk);
      chk(err, "R8 err raised", err, 1);
      chk(!pchg && !wl && !wdrv && !ack, "R8 array outputs off", {pchg, wl, wdrv, ack}, 0);
      short_en = 0; req = 1; we = 0; addr = '0;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         chk(err && !ack && !wl, "R8 sticky halt, no ack", {err, ack, wl}, 3'b100);
      end
      req = 0;
      rst_n = 0;
      @(negedge clk);
      chk_reset_state("R1 reset clears error");
      rst_n = 1;
      repeat (2) @(negedge clk);
      wr(AW'(5), 16'h1234);
      access(1'b0, AW'(5), '0, q);
      chk(q == 16'h1234, "R9 access after recovery", q, 16'h1234);

      repeat (4) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule